// File: doc/BRIEF.md
# Hash Engine Control and Interrupt Front-End

This block is the register-mapped control slice of a multi-algorithm hash accelerator. It sits on a simple 32-bit register bus. Software uses it to hold the engine in a soft reset, program the message length in bits, and pick the algorithm and input byte order. It also arms and acknowledges four sticky interrupt causes. Finished digests are drained one word per read from a result queue that pops on read.

A stub digest source stands in for the compression cores. On a done pulse it writes the digest words into the result queue, one word per cycle, starting with the last word of the digest. Each word is a fixed function of the programmed low length word, the algorithm and the word index, so a consumer can predict every word it pops. Two separate error causes are reported. One flags a read of an empty queue. The other flags a data-port write made before the control register was programmed.

Top module: `hash_ctl_front`

## Requirements
- R1: After the synchronous reset, every readable register reads 0, `irq` is 0 and `msg_bits` is 0.
- R2: Writing 1 to bit 0 of the soft-reset register (byte offset 0x00) holds the block, and the register then reads 1. While held, the queue is emptied and the status bits stay clear. The control fields read 0 and the block is unconfigured. Queue reads return 0 and raise no error, and done pulses are ignored. Writing 0 releases the hold. The length registers and the enable register keep their values.
- R3: The bit length is written in two halves: the upper 32 bits at offset 0x04 and the lower 32 bits at offset 0x08. Both read back, and `msg_bits` shows {high, low}.
- R4: The control register at offset 0x0C holds the algorithm in bits [1:0] (0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256) and the byte order in bits [9:8]. All other bits read 0. A control write outside the hold marks the block configured.
- R5: A pulse on `data_wr` while the block is unconfigured sets status bit 3. Once the block is configured, the pulse has no effect.
- R6: A `core_done` pulse seen while the block is configured and not filling makes the stub push the digest words. There are 4, 5, 7 or 8 words for algorithms 0 to 3. Word k is L ^ {6'h2A, algo[1:0], k[7:0], 16'h5A5A}, where L is the low length word. Word N-1 is pushed first and word 0 last, and pops return them in that order.
- R7: Status bit 0 is set when a word enters the queue. Status bit 1 is set when the last word of a digest has been pushed. A `core_done` pulse that arrives during a fill is ignored.
- R8: A read of the result queue (offset 0x1C) while it is empty returns 0 and sets status bit 2.
- R9: Status bits [3:0] at offset 0x10 are sticky. A write to offset 0x18 clears the bits set in its mask. If a cause fires in the same cycle as the clear, the bit stays set.
- R10: `irq` goes high one cycle after any status bit [3:0] is set with its enable bit set (offset 0x14, bits [3:0]; other bits read 0). Status bit 8 shows a non-empty queue. It cannot be cleared and never raises `irq`.
- R11: Each queue read removes exactly one word. A push and a pop in the same cycle keep both the word order and the fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid next cycle |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| data_wr | input | 1 | Pulse per word written to the data port |
| core_done | input | 1 | Digest finished pulse for the stub source |
| irq | output | 1 | Interrupt request |
| cfg_algo | output | 2 | Selected algorithm |
| cfg_order | output | 2 | Selected byte order |
| msg_bits | output | 64 | Programmed message length in bits |
| core_hold | output | 1 | Soft reset held |

## Verification
Two kinds of collision are exercised. The first is a stub push and a bus pop landing on the same edge. Back-to-back queue reads are started one cycle after the first digest word lands. The bench then requires every word in last-to-first order, no read error and an empty queue at the end. The second is a clear write that coincides with a new error cause. A `data_wr` pulse on an unconfigured block is driven in the same cycle as a clear of all bits. The cause must survive, while a bit that was set earlier in the same mask is removed.

// File: rtl/hfe_pkg.sv
package hfe_pkg;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int NUM_EV   = 4;
  localparam int MAX_DIG  = 8;

  typedef enum logic [1:0] {
    ALG_MD5    = 2'd0,
    ALG_SHA1   = 2'd1,
    ALG_SHA224 = 2'd2,
    ALG_SHA256 = 2'd3
  } alg_e;

  typedef enum logic [2:0] {
    RG_SRST   = 3'd0,
    RG_LEN_HI = 3'd1,
    RG_LEN_LO = 3'd2,
    RG_CTRL   = 3'd3,
    RG_STAT   = 3'd4,
    RG_IEN    = 3'd5,
    RG_ICLR   = 3'd6,
    RG_RQ     = 3'd7
  } reg_e;

  localparam int EV_AVAIL = 0;
  localparam int EV_NEW   = 1;
  localparam int EV_RDERR = 2;
  localparam int EV_WRERR = 3;

  function automatic logic [3:0] words_for(alg_e a);
    case (a)
      ALG_MD5:    return 4'd4;
      ALG_SHA1:   return 4'd5;
      ALG_SHA224: return 4'd7;
      default:    return 4'd8;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] stub_word(logic [WORD_W-1:0] seed, alg_e a,
                                                  logic [7:0] k);
    return seed ^ {6'h2A, a, k, 16'h5A5A};
  endfunction
endpackage

// File: rtl/hfe_regs.sv
module hfe_regs
  import hfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_e              wr_idx,
  input  logic [WORD_W-1:0] wdata,
  output logic              hold,
  output logic              configured,
  output alg_e              algo,
  output logic [1:0]        order,
  output logic [WORD_W-1:0] len_hi,
  output logic [WORD_W-1:0] len_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold       <= 1'b0;
      configured <= 1'b0;
      algo       <= ALG_MD5;
      order      <= 2'd0;
      len_hi     <= '0;
      len_lo     <= '0;
    end else begin
      if (wr_en) begin
        case (wr_idx)
          RG_SRST:   hold   <= wdata[0];
          RG_LEN_HI: len_hi <= wdata;
          RG_LEN_LO: len_lo <= wdata;
          RG_CTRL: if (!hold) begin
            algo       <= alg_e'(wdata[1:0]);
            order      <= wdata[9:8];
            configured <= 1'b1;
          end
          default: ;
        endcase
      end
      if (hold) begin
        algo       <= ALG_MD5;
        order      <= 2'd0;
        configured <= 1'b0;
      end
    end
  end

  AST_CFG_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(configured) |-> $past(wr_en && wr_idx == RG_CTRL && !hold)); // R4
  AST_HOLD_UNCONF: assert property (@(posedge clk) disable iff (rst)
    $past(hold) && hold |-> !configured && algo == ALG_MD5 && order == 2'd0); // R2
endmodule

// File: rtl/hfe_irq.sv
module hfe_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [N-1:0] ev_set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic         ien_we,
  input  logic [N-1:0] ien_wdata,
  output logic [N-1:0] sticky,
  output logic [N-1:0] ien,
  output logic         irq
);
  logic [N-1:0] masked;
  logic [N-1:0] clr_vec;

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign masked[g]  = sticky[g] & ien[g];
    assign clr_vec[g] = clr_we & clr_mask[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky <= '0;
      ien    <= '0;
      irq    <= 1'b0;
    end else begin
      if (hold) sticky <= '0;
      else      sticky <= (sticky & ~clr_vec) | ev_set;
      if (ien_we) ien <= ien_wdata;
      irq <= |masked;
    end
  end

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((sticky & $past(clr_mask & ~ev_set)) == '0)); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|ev_set) && !hold |=> ((sticky & $past(ev_set)) == $past(ev_set))); // R9
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    hold && $past(hold) && $past(hold, 2) |-> !irq); // R2
endmodule

// File: rtl/hfe_rqueue.sv
module hfe_rqueue #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         underflow,
  output logic         nonempty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] count;
  logic             empty, full, do_push, do_pop;

  assign empty     = (count == '0);
  assign full      = (count == FULL_CNT);
  assign do_push   = push && !full && !flush;
  assign do_pop    = pop && !empty && !flush;
  assign underflow = pop && empty && !flush;
  assign nonempty  = !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush)  pop_data <= '0;
    else if (do_pop)   pop_data <= mem[rp];
    else if (pop)      pop_data <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT); // R11
  AST_POP_ONE: assert property (@(posedge clk) disable iff (rst)
    pop && !push && !empty && !flush |=> count == $past(count) - 1'b1); // R11
  AST_PUSH_POP_LEVEL: assert property (@(posedge clk) disable iff (rst)
    pop && push && !empty && !full && !flush |=> count == $past(count)); // R11
endmodule

// File: rtl/hfe_digest_stub.sv
module hfe_digest_stub
  import hfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              start,
  input  logic              configured,
  input  alg_e              algo,
  input  logic [WORD_W-1:0] seed,
  output logic              push,
  output logic [WORD_W-1:0] push_data,
  output logic              last
);
  logic              busy;
  logic [2:0]        idx;
  alg_e              alg_q;
  logic [WORD_W-1:0] seed_q;
  logic              accept;

  assign accept    = start && !busy && !hold && configured;
  assign push      = busy && !hold;
  assign last      = push && (idx == 3'd0);
  assign push_data = stub_word(seed_q, alg_q, {5'd0, idx});

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      busy   <= 1'b0;
      idx    <= 3'd0;
      alg_q  <= ALG_MD5;
      seed_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      idx    <= 3'(words_for(algo) - 4'd1);
      alg_q  <= algo;
      seed_q <= seed;
    end else if (busy) begin
      if (idx == 3'd0) busy <= 1'b0;
      else             idx  <= idx - 1'b1;
    end
  end

  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy && ({1'b0, idx} == $past(words_for(algo)) - 4'd1)); // R6
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy && start && idx != 3'd0 && !hold |=> busy && idx == $past(idx) - 1'b1); // R7
endmodule

// File: rtl/hash_ctl_front.sv
module hash_ctl_front
  import hfe_pkg::*;
#(
  parameter int QDEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              data_wr,
  input  logic              core_done,
  output logic              irq,
  output logic [1:0]        cfg_algo,
  output logic [1:0]        cfg_order,
  output logic [2*WORD_W-1:0] msg_bits,
  output logic              core_hold
);
  reg_e              idx;
  logic              hold, configured;
  alg_e              algo;
  logic [1:0]        order;
  logic [WORD_W-1:0] len_hi, len_lo;
  logic [NUM_EV-1:0] ev_set, sticky, ien;
  logic              q_push, q_last, q_pop, q_under, q_nonempty;
  logic [WORD_W-1:0] q_push_data, q_pop_data;
  logic [WORD_W-1:0] rmux, rd_q;
  logic              sel_rq_q;
  logic [1:0]        unused_addr;

  assign unused_addr = bus_addr[1:0];
  assign idx         = reg_e'(bus_addr[4:2]);

  hfe_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .wr_idx(idx), .wdata(bus_wdata),
    .hold(hold), .configured(configured), .algo(algo), .order(order),
    .len_hi(len_hi), .len_lo(len_lo)
  );

  hfe_digest_stub u_stub (
    .clk(clk), .rst(rst), .hold(hold), .start(core_done), .configured(configured),
    .algo(algo), .seed(len_lo), .push(q_push), .push_data(q_push_data), .last(q_last)
  );

  assign q_pop = bus_rd && (idx == RG_RQ) && !hold;

  hfe_rqueue #(.DEPTH(QDEPTH), .W(WORD_W)) u_queue (
    .clk(clk), .rst(rst), .flush(hold), .push(q_push), .push_data(q_push_data),
    .pop(q_pop), .pop_data(q_pop_data), .underflow(q_under), .nonempty(q_nonempty)
  );

  always_comb begin
    ev_set           = '0;
    ev_set[EV_AVAIL] = q_push;
    ev_set[EV_NEW]   = q_last;
    ev_set[EV_RDERR] = q_under;
    ev_set[EV_WRERR] = data_wr && !configured && !hold;
  end

  hfe_irq #(.N(NUM_EV)) u_irq (
    .clk(clk), .rst(rst), .hold(hold), .ev_set(ev_set),
    .clr_we(bus_wr && idx == RG_ICLR), .clr_mask(bus_wdata[NUM_EV-1:0]),
    .ien_we(bus_wr && idx == RG_IEN), .ien_wdata(bus_wdata[NUM_EV-1:0]),
    .sticky(sticky), .ien(ien), .irq(irq)
  );

  always_comb begin
    rmux = '0;
    case (idx)
      RG_SRST:   rmux[0]   = hold;
      RG_LEN_HI: rmux      = len_hi;
      RG_LEN_LO: rmux      = len_lo;
      RG_CTRL:   begin rmux[1:0] = algo; rmux[9:8] = order; end
      RG_STAT:   begin rmux[NUM_EV-1:0] = sticky; rmux[8] = q_nonempty; end
      RG_IEN:    rmux[NUM_EV-1:0] = ien;
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= '0;
      sel_rq_q <= 1'b0;
    end else if (bus_rd) begin
      rd_q     <= rmux;
      sel_rq_q <= (idx == RG_RQ);
    end
  end

  assign bus_rdata = sel_rq_q ? q_pop_data : rd_q;
  assign cfg_algo  = algo;
  assign cfg_order = order;
  assign msg_bits  = {len_hi, len_lo};
  assign core_hold = hold;

  AST_EMPTY_READ_ERR: assert property (@(posedge clk) disable iff (rst)
    q_pop && !q_nonempty |=> sticky[EV_RDERR]); // R8
  AST_WRERR_ONLY_UNCONF: assert property (@(posedge clk) disable iff (rst)
    $rose(sticky[EV_WRERR]) |-> $past(data_wr && !configured)); // R5
endmodule

// File: tb/hash_ctl_front_tb_top.sv
module hash_ctl_front_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, data_wr = 1'b0, core_done = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, core_hold;
  logic [1:0]  cfg_algo, cfg_order;
  logic [63:0] msg_bits;
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  hash_ctl_front dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .data_wr(data_wr),
    .core_done(core_done), .irq(irq), .cfg_algo(cfg_algo), .cfg_order(cfg_order),
    .msg_bits(msg_bits), .core_hold(core_hold)
  );

  localparam logic [4:0] A_SRST = 5'h00, A_HI = 5'h04, A_LO = 5'h08, A_CTRL = 5'h0C,
                         A_STAT = 5'h10, A_IEN = 5'h14, A_CLR = 5'h18, A_RQ = 5'h1C;

  function automatic int n_words(logic [1:0] a);
    case (a) 2'd0: return 4; 2'd1: return 5; 2'd2: return 7; default: return 8; endcase
  endfunction

  function automatic logic [31:0] exp_word(logic [31:0] l, logic [1:0] a, int k);
    return l ^ {6'h2A, a, 8'(k), 16'h5A5A};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); core_done = 1'b1;
    @(negedge clk); core_done = 1'b0;
  endtask

  task automatic pulse_data();
    @(negedge clk); data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain_check(string req, logic [31:0] l, logic [1:0] a);
    logic [31:0] v;
    for (int k = n_words(a) - 1; k >= 0; k--) begin
      rd(A_RQ, v);
      check(req, v, exp_word(l, a, k));
    end
  endtask

  initial begin
    logic [31:0] v, lo, hi;
    logic [1:0]  a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    for (int r = 0; r < 7; r++) begin
      rd(5'(r * 4), v);
      check("R1 reg readback", v, 0);
    end
    check("R1 irq", irq, 0);
    check("R1 msg_bits", msg_bits, 0);

    // R5 data write before configuration, R10 irq
    pulse_data();
    idle(1);
    rd(A_STAT, v); check("R5 write error bit3", v, 32'h8);
    check("R10 irq masked", irq, 0);
    wr(A_IEN, 32'h1FF);
    idle(2);
    check("R10 irq enabled", irq, 1);
    rd(A_IEN, v); check("R10 enable width", v, 32'hF);
    wr(A_CLR, 32'h8);
    idle(2);
    rd(A_STAT, v); check("R9 clear", v, 0);
    check("R10 irq drops", irq, 0);

    // R9 clear and set in same cycle: bit3 survives, bit2 cleared
    rd(A_RQ, v); check("R8 empty read data", v, 0);
    rd(A_STAT, v); check("R8 read error bit2", v, 32'h4);
    @(negedge clk); bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'hF; data_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; data_wr = 1'b0;
    rd(A_STAT, v); check("R9 set wins over clear", v, 32'h8);
    wr(A_CLR, 32'hF);

    // R3 length
    hi = $urandom; lo = $urandom;
    wr(A_HI, hi); wr(A_LO, lo);
    rd(A_HI, v); check("R3 high", v, hi);
    rd(A_LO, v); check("R3 low", v, lo);
    check("R3 msg_bits", msg_bits, {hi, lo});

    // R4 control
    v = $urandom;
    wr(A_CTRL, v);
    rd(A_CTRL, lo); check("R4 control mask", lo, v & 32'h303);
    check("R4 algo out", cfg_algo, v[1:0]);
    check("R4 order out", cfg_order, v[9:8]);
    pulse_data(); idle(1);
    rd(A_STAT, lo); check("R5 no error once configured", lo, 0);

    // R6 R7 R8 random rounds
    for (int r = 0; r < 8; r++) begin
      a  = (r < 4) ? 2'(r) : 2'($urandom);
      lo = $urandom;
      wr(A_CTRL, {22'd0, 2'($urandom), 6'd0, a});
      wr(A_LO, lo);
      wr(A_CLR, 32'hF);
      pulse_done();
      idle(10);
      rd(A_STAT, v); check("R7 avail+new+nonempty", v, 32'h103);
      drain_check("R6 word order", lo, a);
      rd(A_STAT, v); check("R10 bit8 after drain", v, 32'h3);
      rd(A_RQ, v); check("R8 extra read zero", v, 0);
      rd(A_STAT, v); check("R8 error after drain", v, 32'h7);
    end

    // R11 pops overlapping pushes
    wr(A_CTRL, 32'h3); lo = $urandom; wr(A_LO, lo); wr(A_CLR, 32'hF);
    @(negedge clk); core_done = 1'b1;
    @(negedge clk); core_done = 1'b0;
    @(negedge clk); bus_rd = 1'b1; bus_addr = A_RQ;
    for (int k = 7; k >= 0; k--) begin
      @(negedge clk);
      check("R11 pop during fill", bus_rdata, exp_word(lo, 2'd3, k));
    end
    bus_rd = 1'b0;
    rd(A_STAT, v); check("R11 no underflow, empty", v, 32'h3);

    // R7 second done during fill ignored
    wr(A_CTRL, 32'h1); lo = $urandom; wr(A_LO, lo); wr(A_CLR, 32'hF);
    pulse_done(); pulse_done(); idle(10);
    drain_check("R7 single fill", lo, 2'd1);
    rd(A_RQ, v); check("R7 no second digest", v, 0);

    // R10 bit8 does not interrupt and cannot be cleared
    wr(A_CTRL, 32'h0); lo = $urandom; wr(A_LO, lo);
    pulse_done(); idle(8);
    wr(A_CLR, 32'h1FF); idle(2);
    rd(A_STAT, v); check("R10 bit8 uncleared", v, 32'h100);
    check("R10 bit8 no irq", irq, 0);

    // R2 soft reset hold
    hi = msg_bits[63:32];
    wr(A_SRST, 32'h1); idle(3);
    rd(A_SRST, v); check("R2 reset reads 1", v, 1);
    rd(A_STAT, v); check("R2 status clear", v, 0);
    wr(A_CTRL, 32'h302);
    rd(A_CTRL, v); check("R2 control ignored", v, 0);
    rd(A_RQ, v); check("R2 queue read zero", v, 0);
    pulse_done(); pulse_data(); idle(10);
    rd(A_STAT, v); check("R2 no events in hold", v, 0);
    check("R2 irq low", irq, 0);
    check("R2 hold out", core_hold, 1);
    wr(A_SRST, 32'h0);
    rd(A_RQ, v); check("R2 queue emptied", v, 0);
    rd(A_STAT, v); check("R2 empty after release", v, 32'h4);
    rd(A_IEN, v); check("R2 enable kept", v, 32'hF);
    check("R2 length kept", msg_bits, {hi, lo});
    pulse_data(); idle(1);
    rd(A_STAT, v); check("R2 unconfigured after release", v, 32'hC);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule